// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

This block adds two binary32 floating-point numbers over several clock cycles under a small state machine. A one-cycle `start` pulse loads both operands. Each operand is split into sign, biased exponent and significand, with the hidden one restored. Subnormal operands are treated as zero. The block first resolves NaN and infinity cases. For ordinary operands it puts the larger magnitude first and shifts the other significand right by one bit per cycle until the exponents agree. It then adds or subtracts, normalizes, and rounds to nearest. It keeps exactly two extra low-order bits, guard and round, below the significand; any bit shifted below the round bit is discarded. If rounding carries out of the significand, the block goes back to normalization. When the result is ready, `done` pulses for one cycle. `result` and the two flags then hold their values until the next accepted `start`.

The states are IDLE, SPECIAL, ALIGN, ADD, NORM, ROUND and DONE. The transitions are:
- IDLE→SPECIAL on `start`.
- SPECIAL→DONE when a NaN or infinity decides the answer; otherwise SPECIAL→ALIGN.
- ALIGN stays in ALIGN while the shift count is non-zero; otherwise ALIGN→ADD.
- ADD→NORM always.
- NORM stays in NORM while it shifts right (carry) or left (leading zero).
- NORM→DONE on an exact zero, an overflow or an underflow.
- NORM→ROUND once the significand is normalized and the exponent is in range.
- ROUND→NORM when rounding carries out; otherwise ROUND→DONE.
- DONE→IDLE always.

Top module: `fpadd_seq`

## Requirements
- R1: For two finite operands of the same sign, the magnitudes are added after alignment, normalized and rounded. The result has that common sign, the 8-bit biased exponent in bits 30:23 and the 23-bit fraction in bits 22:0.
- R2: For operands of opposite sign, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. An exact zero is returned as 0x00000000.
- R3: Alignment keeps exactly two bits below the significand LSB, guard then round. Bits shifted below the round bit are lost. The significand is incremented only when guard is 1 and either round or the LSB is 1.
- R4: When rounding carries out of the 24-bit significand, the result is renormalized: the significand shifts right one place and the exponent goes up by one.
- R5: A NaN operand (exponent 255, non-zero fraction) gives 0x7FC00000. Infinities of opposite sign also give 0x7FC00000.
- R6: An infinity (exponent 255, zero fraction) added to a finite value, or to an infinity of the same sign, returns that infinity.
- R7: If the normalized exponent reaches 255 or more, the result is a signed infinity and `ovf` is 1.
- R8: If the normalized exponent falls to 0 or below, the result is a signed zero and `unf` is 1.
- R9: An operand whose exponent field is 0 is treated as zero, whatever its fraction.
- R10: After reset, `done`, `result`, `ovf` and `unf` are 0. `done` is high for exactly one cycle per operation. A `start` that arrives while an operation is in progress is ignored.
- R11: `ovf` and `unf` are never both 1. Both are cleared when a new operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an addition; accepted only in IDLE |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| result | output | 32 | Binary32 sum, held until the next accepted start |
| done | output | 1 | One-cycle pulse when `result` is valid |
| ovf | output | 1 | Exponent overflow of the last operation |
| unf | output | 1 | Exponent underflow of the last operation |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. These widths bring within reach the real binary32 corner values:
- the largest finite value doubling into infinity;
- the smallest normal number cancelling into underflow;
- exact ties at an exponent gap of 24, where guard alone is set;
- gaps of 26 or more, where the smaller operand vanishes completely.

A behavioural reference model in the bench predicts every result. Random operand pairs are mixed with close-exponent pairs so that cancellation and the left-shift normalization path are exercised.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SPECIAL, S_ALIGN, S_ADD, S_NORM, S_ROUND, S_DONE
    } fpadd_state_t;

    // extra low-order bits carried below the significand: guard, round
    localparam int XTRA = 2;
endpackage

// File: rtl/fpadd_unpack.sv
`timescale 1ns/1ps
module fpadd_unpack
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]       op,
    output logic                       sgn,
    output logic [EXP_W-1:0]           expo,
    output logic [MAN_W+XTRA:0]        sig,
    output logic                       is_nan,
    output logic                       is_inf
);
    logic exp_max, exp_min, frac_nz;

    always_comb begin
        sgn     = op[EXP_W+MAN_W];
        expo    = op[EXP_W+MAN_W-1:MAN_W];
        exp_max = &expo;
        exp_min = ~|expo;
        frac_nz = |op[MAN_W-1:0];
        is_nan  = exp_max & frac_nz;
        is_inf  = exp_max & ~frac_nz;
        // subnormals flush to zero; hidden one restored otherwise
        sig     = exp_min ? '0 : {1'b1, op[MAN_W-1:0], {XTRA{1'b0}}};
    end
endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
module fpadd_round
    import fpadd_pkg::*;
#(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W+XTRA-1:0] ext,
    output logic [SIG_W:0]        rnd,
    output logic                  carry
);
    logic guard_b, round_b, lsb_b, bump;

    always_comb begin
        guard_b = ext[XTRA-1];
        round_b = ext[XTRA-2];
        lsb_b   = ext[XTRA];
        bump    = guard_b & (round_b | lsb_b);
        rnd     = {1'b0, ext[SIG_W+XTRA-1:XTRA]} + {{SIG_W{1'b0}}, bump};
        carry   = rnd[SIG_W];
    end
endmodule

// File: rtl/fpadd_seq.sv
`timescale 1ns/1ps
module fpadd_seq
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [EXP_W+MAN_W:0]   op_a,
    input  logic [EXP_W+MAN_W:0]   op_b,
    output logic [EXP_W+MAN_W:0]   result,
    output logic                   done,
    output logic                   ovf,
    output logic                   unf
);
    localparam int W     = EXP_W + MAN_W + 1;
    localparam int SIG_W = MAN_W + 1;
    localparam int EXT_W = SIG_W + XTRA;
    localparam int ACC_W = EXT_W + 1;
    localparam int ER_W  = EXP_W + 2;
    localparam int CNT_W = $clog2(EXT_W + 1);
    localparam int EMAX  = (1 << EXP_W) - 1;
    localparam logic signed [ER_W-1:0] EMAX_S = ER_W'(EMAX);
    localparam logic signed [ER_W-1:0] ZERO_S = '0;
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    fpadd_state_t state_q, state_d;

    // unpacked operand fields, live on the ports
    logic             pa_sgn, pb_sgn, pa_nan, pb_nan, pa_inf, pb_inf;
    logic [EXP_W-1:0] pa_exp, pb_exp;
    logic [EXT_W-1:0] pa_sig, pb_sig;

    fpadd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_a (
        .op(op_a), .sgn(pa_sgn), .expo(pa_exp), .sig(pa_sig),
        .is_nan(pa_nan), .is_inf(pa_inf));
    fpadd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_b (
        .op(op_b), .sgn(pb_sgn), .expo(pb_exp), .sig(pb_sig),
        .is_nan(pb_nan), .is_inf(pb_inf));

    // captured operands and working registers
    logic                    sgn_a_q, sgn_b_q, nan_a_q, nan_b_q, inf_a_q, inf_b_q;
    logic [EXP_W-1:0]        exp_a_q, exp_b_q;
    logic [EXT_W-1:0]        sig_a_q, sig_b_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [ACC_W-1:0]        acc_q;
    logic signed [ER_W-1:0]  exp_r_q;
    logic                    sgn_r_q, sub_q;
    logic [W-1:0]            res_q;
    logic                    ovf_q, unf_q;

    // combinational decisions
    logic             any_nan, spec_hit, a_big, far;
    logic [W-1:0]     spec_res;
    logic [EXP_W-1:0] gap;
    logic             acc_zero, acc_carry, acc_norm, exp_hi, exp_lo;
    logic [SIG_W:0]   rnd_val;
    logic             rnd_carry;

    fpadd_round #(.SIG_W(SIG_W)) u_rnd (
        .ext(acc_q[EXT_W-1:0]), .rnd(rnd_val), .carry(rnd_carry));

    always_comb begin
        any_nan   = nan_a_q | nan_b_q | (inf_a_q & inf_b_q & (sgn_a_q ^ sgn_b_q));
        spec_hit  = any_nan | inf_a_q | inf_b_q;
        spec_res  = any_nan ? QNAN : (inf_a_q ? {sgn_a_q, INF_MAG} : {sgn_b_q, INF_MAG});
        a_big     = {exp_a_q, sig_a_q} >= {exp_b_q, sig_b_q};
        gap       = a_big ? (exp_a_q - exp_b_q) : (exp_b_q - exp_a_q);
        far       = int'(gap) >= EXT_W;
        acc_zero  = ~|acc_q;
        acc_carry = acc_q[ACC_W-1];
        acc_norm  = acc_q[ACC_W-2];
        exp_hi    = exp_r_q >= EMAX_S;
        exp_lo    = exp_r_q <= ZERO_S;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_SPECIAL;
            S_SPECIAL: state_d = spec_hit ? S_DONE : S_ALIGN;
            S_ALIGN:   if (cnt_q == '0) state_d = S_ADD;
            S_ADD:     state_d = S_NORM;
            S_NORM: begin
                if (acc_zero)
                    state_d = S_DONE;
                else if (!acc_carry && acc_norm)
                    state_d = (exp_hi || exp_lo) ? S_DONE : S_ROUND;
            end
            S_ROUND:   state_d = rnd_carry ? S_NORM : S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgn_a_q <= 1'b0; sgn_b_q <= 1'b0; nan_a_q <= 1'b0; nan_b_q <= 1'b0;
            inf_a_q <= 1'b0; inf_b_q <= 1'b0; exp_a_q <= '0; exp_b_q <= '0;
            sig_a_q <= '0; sig_b_q <= '0; cnt_q <= '0; acc_q <= '0;
            exp_r_q <= '0; sgn_r_q <= 1'b0; sub_q <= 1'b0;
            res_q <= '0; ovf_q <= 1'b0; unf_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    sgn_a_q <= pa_sgn; sgn_b_q <= pb_sgn;
                    nan_a_q <= pa_nan; nan_b_q <= pb_nan;
                    inf_a_q <= pa_inf; inf_b_q <= pb_inf;
                    exp_a_q <= pa_exp; exp_b_q <= pb_exp;
                    sig_a_q <= pa_sig; sig_b_q <= pb_sig;
                    ovf_q   <= 1'b0;   unf_q   <= 1'b0;
                end
                S_SPECIAL: begin
                    if (spec_hit) begin
                        res_q <= spec_res;
                    end else begin
                        sig_a_q <= a_big ? sig_a_q : sig_b_q;
                        sig_b_q <= far ? '0 : (a_big ? sig_b_q : sig_a_q);
                        exp_r_q <= a_big ? ER_W'(exp_a_q) : ER_W'(exp_b_q);
                        sgn_r_q <= a_big ? sgn_a_q : sgn_b_q;
                        sub_q   <= sgn_a_q ^ sgn_b_q;
                        cnt_q   <= far ? '0 : CNT_W'(gap);
                    end
                end
                S_ALIGN: if (cnt_q != '0) begin
                    sig_b_q <= sig_b_q >> 1;
                    cnt_q   <= cnt_q - 1'b1;
                end
                S_ADD: begin
                    acc_q <= sub_q ? ({1'b0, sig_a_q} - {1'b0, sig_b_q})
                                   : ({1'b0, sig_a_q} + {1'b0, sig_b_q});
                end
                S_NORM: begin
                    if (acc_zero) begin
                        res_q <= '0;
                    end else if (acc_carry) begin
                        acc_q   <= acc_q >> 1;
                        exp_r_q <= exp_r_q + ER_W'(1);
                    end else if (!acc_norm) begin
                        acc_q   <= acc_q << 1;
                        exp_r_q <= exp_r_q - ER_W'(1);
                    end else if (exp_hi) begin
                        res_q <= {sgn_r_q, INF_MAG};
                        ovf_q <= 1'b1;
                    end else if (exp_lo) begin
                        res_q <= {sgn_r_q, {(W-1){1'b0}}};
                        unf_q <= 1'b1;
                    end
                end
                S_ROUND: begin
                    acc_q <= {rnd_val, {XTRA{1'b0}}};
                    if (!rnd_carry)
                        res_q <= {sgn_r_q, exp_r_q[EXP_W-1:0], rnd_val[MAN_W-1:0]};
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == S_DONE);
        result = res_q;
        ovf    = ovf_q;
        unf    = unf_q;
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a new operation only begins from IDLE, so a busy start cannot restart it
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (state_q != S_SPECIAL));
    // R4: the rounder only ever sees a normalized significand without carry
    a_r4_round_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ROUND) |-> (acc_q[ACC_W-2] && !acc_q[ACC_W-1]));
    // R2: an exact cancellation finishes next cycle with +0
    a_r2_exact_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NORM && acc_q == '0) |=> (done && result == '0));
    // R7: overflow flag comes with an infinity
    a_r7_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (result[W-2:0] == INF_MAG));
    // R8: underflow flag comes with a zero magnitude
    a_r8_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (result[W-2:0] == '0));
    // R11: flags are exclusive
    a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));
endmodule

// File: tb/sim_fpadd_seq.sv
`timescale 1ns/1ps
module sim_fpadd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic        done, ovf, unf;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    fpadd_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .result(result), .done(done), .ovf(ovf), .unf(unf));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R10 watchdog expired actual=%0d expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: returns {ovf, unf, result}
    function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] big, sml;
        int eb, es, e, d;
        longint mb, ms, v, m;
        bit s, inc, a_nan, b_nan, a_inf, b_inf;
        a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        b_inf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        if (a_nan || b_nan) return {2'b00, 32'h7FC00000};
        if (a_inf && b_inf && (a[31] != b[31])) return {2'b00, 32'h7FC00000};
        if (a_inf) return {2'b00, a};
        if (b_inf) return {2'b00, b};
        if (b[30:0] > a[30:0]) begin big = b; sml = a; end
        else begin big = a; sml = b; end
        eb = int'(big[30:23]);
        es = int'(sml[30:23]);
        mb = (eb == 0) ? 64'sd0 : (longint'({1'b1, big[22:0]}) << 2);
        ms = (es == 0) ? 64'sd0 : (longint'({1'b1, sml[22:0]}) << 2);
        d  = eb - es;
        ms = (d >= 26) ? 64'sd0 : (ms >> d);
        v  = (big[31] == sml[31]) ? (mb + ms) : (mb - ms);
        s  = big[31];
        if (v == 0) return 34'd0;
        e = eb;
        if (v >= (longint'(1) << 26)) begin v = v >> 1; e++; end
        while (v < (longint'(1) << 25)) begin v = v << 1; e--; end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'h0};
        if (e <= 0)   return {2'b01, s, 31'h0};
        inc = v[1] & (v[0] | v[2]);
        m = (v >> 2) + longint'(inc);
        if (m >= (longint'(1) << 24)) begin m = m >> 1; e++; end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'h0};
        return {2'b00, s, e[7:0], m[22:0]};
    endfunction

    logic [33:0] last;

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
        logic [33:0] e;
        int n;
        e = ref_add(a, b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        check(done, req, "done never seen", 64'(done), 64'd1);
        last = {ovf, unf, result};
        check(last == e, req, "sum vs model", 64'(last), 64'(e));
        @(negedge clk);
        check(!done, "R10", "done longer than one cycle", 64'(done), 64'd0);
    endtask

    task automatic run_lit(input logic [31:0] a, input logic [31:0] b,
                           input logic [33:0] lit, input string req);
        run_op(a, b, req);
        check(last == lit, req, "sum vs literal", 64'(last), 64'(lit));
    endtask

    initial begin
        logic [33:0] e1;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({done, ovf, unf, result} == 35'd0, "R10", "reset state",
              64'({done, ovf, unf, result}), 64'd0);

        // R1 same-sign sums
        run_lit(32'h3F800000, 32'h3F800000, {2'b00, 32'h40000000}, "R1");
        run_lit(32'h3F400000, 32'h41740000, {2'b00, 32'h41800000}, "R1");
        // R2 opposite signs
        run_lit(32'h3F000000, 32'hBEE00000, {2'b00, 32'h3D800000}, "R2");
        run_lit(32'h40490FDB, 32'hC0490FDB, {2'b00, 32'h00000000}, "R2");
        run_lit(32'hC0000000, 32'h3F800000, {2'b00, 32'hBF800000}, "R2");
        // R3 guard/round behaviour
        run_lit(32'h3F800000, 32'h33800000, {2'b00, 32'h3F800000}, "R3");
        run_lit(32'h3F800001, 32'h33800000, {2'b00, 32'h3F800002}, "R3");
        run_lit(32'h3F800000, 32'h33C00000, {2'b00, 32'h3F800001}, "R3");
        run_lit(32'h3F800000, 32'h33A00000, {2'b00, 32'h3F800000}, "R3");
        // R4 rounding carry
        run_lit(32'h3FFFFFFF, 32'h33800000, {2'b00, 32'h40000000}, "R4");
        // R5 NaN
        run_lit(32'h7FC00001, 32'h3F800000, {2'b00, 32'h7FC00000}, "R5");
        run_lit(32'h7F800000, 32'hFF800000, {2'b00, 32'h7FC00000}, "R5");
        // R6 infinity
        run_lit(32'hFF800000, 32'h3F800000, {2'b00, 32'hFF800000}, "R6");
        run_lit(32'h7F800000, 32'h7F800000, {2'b00, 32'h7F800000}, "R6");
        // R7 overflow
        run_lit(32'h7F7FFFFF, 32'h7F7FFFFF, {2'b10, 32'h7F800000}, "R7");
        run_lit(32'hFF7FFFFF, 32'hFF7FFFFF, {2'b10, 32'hFF800000}, "R7");
        // R11 flags cleared by the next operation
        run_lit(32'h3F800000, 32'h3F800000, {2'b00, 32'h40000000}, "R11");
        // R8 underflow
        run_lit(32'h00800000, 32'h80800001, {2'b01, 32'h80000000}, "R8");
        // R9 subnormal flush
        run_lit(32'h00000001, 32'h3F800000, {2'b00, 32'h3F800000}, "R9");
        run_lit(32'h00400000, 32'h80200000, {2'b00, 32'h00000000}, "R9");
        run_lit(32'h807FFFFF, 32'h00800000, {2'b00, 32'h00800000}, "R9");

        // R10 start while busy is ignored
        e1 = ref_add(32'h3F800000, 32'h35800000);
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'h35800000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        check(done, "R10", "done never seen", 64'(done), 64'd1);
        check({ovf, unf, result} == e1, "R10", "busy start changed result",
              64'({ovf, unf, result}), 64'(e1));
        @(negedge clk);
        check(!done, "R10", "second done from ignored start", 64'(done), 64'd0);
        repeat (3) begin
            @(negedge clk);
            check(!done, "R10", "late done from ignored start", 64'(done), 64'd0);
        end

        // R1/R2 random mix, half with nearby exponents
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 2 == 0) rb[30:23] = ra[30:23] ^ 8'($urandom() % 4);
            run_op(ra, rb, (ra[31] == rb[31]) ? "R1" : "R2");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule